// File: doc/BRIEF.md
# Partial-Word Left/Right Load-Store Merge Unit

This unit carries out the eight unaligned left/right access operations of a big-endian 64-bit core. These are word and doubleword loads and stores that each touch only part of a memory word. On a start strobe it forms the effective address and checks it for an addressing fault. It then fetches the aligned memory word through a request/grant/response interface. The fetched bytes are merged with either the old register value or the old memory contents.

A load ends with a one-cycle register write carrying the merged value. A store sends the merged word back to the same aligned address, so every store is a read-modify-write. A faulting access raises an exception strobe with a load or store code and has no other side effect. No address translation is done: the effective address goes straight onto the memory bus.

The operation code uses three bits:
- bit 2 set means store.
- bit 1 set means doubleword.
- bit 0 set means the right form.

Left loads shift the fetched word up by eight times the byte offset. Right forms use the complementary byte offset and the opposite shift direction.

Top module: `partial_access_unit`

## Requirements
- R1: The effective address is `base_i` plus `imm_i` sign-extended to 64 bits. The operation code is `op_i` = {store, dword, right}. Every memory request carries that address with bits [1:0] cleared for word forms and bits [2:0] cleared for doubleword forms. `mem_size_o` is 1 for doubleword and 0 for word. Word data travels in bits [31:0] of the data buses.
- R2: Left word load, k = addr[1:0], s = 8k, m = ones32<<s. The result is ((rt & ~m) | (mem<<s)) over 32 bits, sign-extended to 64 bits.
- R3: Right word load, s = 8*(3-k), m = ones32>>s. The result is ((rt & ~m) | (mem>>s)), sign-extended from bit 31.
- R4: Doubleword loads use the same two rules over 64 bits with k = addr[2:0] and 7-k, with no extension.
- R5: Left word store writes (mem & ~(ones32>>s)) | (rt>>s) with s = 8k. Right word store writes (mem & ~(ones32<<s)) | (rt<<s) with s = 8*(3-k).
- R6: Doubleword stores use the R5 rules over 64 bits with k = addr[2:0].
- R7: A store makes exactly one aligned read followed by exactly one aligned write, and never writes the register. A load makes one read, no write, and one `rf_we_o` pulse. `done_o` pulses once, after the load data returns or after the store write is granted.
- R8: With `addr64_i` low, an address that differs from the sign extension of its low 32 bits is a fault. With `addr64_i` high, no address faults.
- R9: On a fault, `exc_o` pulses once with `exc_code_o` = 1 for loads or 2 for stores. No memory request, register write or done pulse follows.
- R10: After reset every output is low and the unit is idle.
- R11: A start strobe that arrives while an operation is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| op_i | input | 3 | {store, dword, right} operation code |
| base_i | input | 64 | Base register value |
| imm_i | input | 16 | Signed address offset |
| rt_i | input | 64 | Data register value (merge source / store data) |
| addr64_i | input | 1 | 1 = 64-bit addressing, 0 = 32-bit addressing |
| mem_req_o | output | 1 | Memory request, held until granted |
| mem_we_o | output | 1 | Request is a write |
| mem_size_o | output | 1 | 1 = doubleword, 0 = word |
| mem_addr_o | output | 64 | Aligned request address |
| mem_wdata_o | output | 64 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| rf_we_o | output | 1 | Register write strobe |
| rf_wdata_o | output | 64 | Register write data |
| done_o | output | 1 | Operation completed |
| exc_o | output | 1 | Address fault strobe |
| exc_code_o | output | 2 | 1 = load fault, 2 = store fault (valid with exc_o) |

## Verification
The assertions assume the memory side behaves in a fixed way:
- It raises the grant only while a request is pending.
- It returns exactly one read response, no earlier than the cycle after the read was granted.
- It never returns read data for a write.

The bench's memory model keeps to this. It grants each request in the cycle after it appears and returns read data one cycle after the grant. It changes its signals only on the falling clock edge.

Start pulses are also given between operations. The one exception is the test that deliberately strobes start mid-operation to show it is ignored.

// File: rtl/pau_pkg.sv
package pau_pkg;
  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_LOAD  = 2'd1,
    EXC_STORE = 2'd2
  } exc_code_e;

  typedef struct packed {
    logic store;
    logic dword;
    logic right;
  } op_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RREQ  = 2'd1,
    ST_RWAIT = 2'd2,
    ST_WREQ  = 2'd3
  } state_e;
endpackage

// File: rtl/pau_agen.sv
module pau_agen #(
  parameter int XLEN     = 64,
  parameter int IMM_W    = 16,
  parameter int NARROW_W = 32
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  logic             wide_mode,
  output logic [XLEN-1:0]  ea,
  output logic             fault
);
  localparam int EXT_W = XLEN - IMM_W;
  localparam int HI_W  = XLEN - NARROW_W;

  always_comb begin
    ea    = base + {{EXT_W{imm[IMM_W-1]}}, imm};
    fault = !wide_mode && (ea != {{HI_W{ea[NARROW_W-1]}}, ea[NARROW_W-1:0]});
  end
endmodule

// File: rtl/pau_merge.sv
module pau_merge
  import pau_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  op_t              op,
  input  logic [2:0]       lo,
  input  logic [DATA_W-1:0] rt,
  input  logic [DATA_W-1:0] mem,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] ld_res [2];
  logic [DATA_W-1:0] st_res [2];

  // g = 0: full width, g = 1: half width
  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int W  = DATA_W >> g;
    localparam int LB = $clog2(W / 8);
    logic [LB-1:0]  k;
    logic [LB+2:0]  sh;
    logic [W-1:0]   r, m, ones, ld_v, st_v;

    always_comb begin
      k    = lo[LB-1:0];
      sh   = op.right ? {~k, 3'b000} : {k, 3'b000};
      r    = rt[W-1:0];
      m    = mem[W-1:0];
      ones = '1;
      if (op.right) begin
        ld_v = (r & ~(ones >> sh)) | (m >> sh);
        st_v = (m & ~(ones << sh)) | (r << sh);
      end else begin
        ld_v = (r & ~(ones << sh)) | (m << sh);
        st_v = (m & ~(ones >> sh)) | (r >> sh);
      end
    end

    if (g == 0) begin : g_full
      assign ld_res[g] = ld_v;
      assign st_res[g] = st_v;
    end else begin : g_half
      assign ld_res[g] = {{(DATA_W - W){ld_v[W-1]}}, ld_v};
      assign st_res[g] = {{(DATA_W - W){1'b0}}, st_v};
    end
  end

  always_comb begin
    if (op.store) res = op.dword ? st_res[0] : st_res[1];
    else          res = op.dword ? ld_res[0] : ld_res[1];
  end
endmodule

// File: rtl/partial_access_unit.sv
module partial_access_unit
  import pau_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int IMM_W    = 16,
  parameter int NARROW_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0] rt_i,
  input  logic            addr64_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic            mem_size_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            rf_we_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            done_o,
  output logic            exc_o,
  output logic [1:0]      exc_code_o
);
  localparam int DW_LB = $clog2(XLEN / 8);
  localparam int W_LB  = $clog2(NARROW_W / 8);

  state_e            state;
  op_t               op_in, op_q;
  logic [XLEN-1:0]   rt_q;
  logic [2:0]        lo_q;
  logic [XLEN-1:0]   ea, aligned, merged;
  logic              fault;

  assign op_in = op_t'(op_i);

  pau_agen #(.XLEN(XLEN), .IMM_W(IMM_W), .NARROW_W(NARROW_W)) u_agen (
    .base      (base_i),
    .imm       (imm_i),
    .wide_mode (addr64_i),
    .ea        (ea),
    .fault     (fault)
  );

  pau_merge #(.DATA_W(XLEN)) u_merge (
    .op  (op_q),
    .lo  (lo_q),
    .rt  (rt_q),
    .mem (mem_rdata_i),
    .res (merged)
  );

  always_comb begin
    if (op_in.dword) aligned = {ea[XLEN-1:DW_LB], {DW_LB{1'b0}}};
    else             aligned = {ea[XLEN-1:W_LB], {W_LB{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= '0;
      rt_q        <= '0;
      lo_q        <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_size_o  <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rf_we_o     <= 1'b0;
      rf_wdata_o  <= '0;
      done_o      <= 1'b0;
      exc_o       <= 1'b0;
      exc_code_o  <= EXC_NONE;
    end else begin
      rf_we_o    <= 1'b0;
      done_o     <= 1'b0;
      exc_o      <= 1'b0;
      exc_code_o <= EXC_NONE;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            op_q <= op_in;
            rt_q <= rt_i;
            lo_q <= ea[2:0];
            if (fault) begin
              exc_o      <= 1'b1;
              exc_code_o <= op_in.store ? EXC_STORE : EXC_LOAD;
            end else begin
              mem_req_o  <= 1'b1;
              mem_we_o   <= 1'b0;
              mem_size_o <= op_in.dword;
              mem_addr_o <= aligned;
              state      <= ST_RREQ;
            end
          end
        end
        ST_RREQ: begin
          if (mem_gnt_i) begin
            mem_req_o <= 1'b0;
            state     <= ST_RWAIT;
          end
        end
        ST_RWAIT: begin
          if (mem_rvalid_i) begin
            if (op_q.store) begin
              mem_req_o   <= 1'b1;
              mem_we_o    <= 1'b1;
              mem_wdata_o <= merged;
              state       <= ST_WREQ;
            end else begin
              rf_we_o    <= 1'b1;
              rf_wdata_o <= merged;
              done_o     <= 1'b1;
              state      <= ST_IDLE;
            end
          end
        end
        ST_WREQ: begin
          if (mem_gnt_i) begin
            mem_req_o <= 1'b0;
            mem_we_o  <= 1'b0;
            done_o    <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pau_checker.sv
module pau_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic            mem_size_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_gnt_i,
  input logic            rf_we_o,
  input logic            done_o,
  input logic            exc_o,
  input logic [1:0]      exc_code_o
);
  // R1
  dword_align_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_size_o) |-> (mem_addr_o[2:0] == 3'b000));

  // R1
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_size_o) |-> (mem_addr_o[1:0] == 2'b00));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R7
  load_done_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (done_o && !mem_req_o));

  // R7
  write_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o && mem_gnt_i) |=> (done_o && !rf_we_o));

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> (!done_o && !rf_we_o && !mem_req_o && exc_code_o != 2'd0));
endmodule

bind partial_access_unit pau_checker #(.XLEN(XLEN)) u_pau_checker (
  .clk        (clk),
  .rst        (rst),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_size_o (mem_size_o),
  .mem_addr_o (mem_addr_o),
  .mem_gnt_i  (mem_gnt_i),
  .rf_we_o    (rf_we_o),
  .done_o     (done_o),
  .exc_o      (exc_o),
  .exc_code_o (exc_code_o)
);

// File: tb/test_partial_access_unit.sv
`timescale 1ns/1ps
module test_partial_access_unit;
  localparam logic [63:0] PATTERN = 64'h0011223344556677;
  localparam logic [63:0] RTVAL   = 64'h8899AABBCCDDEEFF;

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] base;
    logic [15:0] imm;
    logic [63:0] expv;
  } vec_t;

  localparam int NV = 16;
  // loads: expv = register result; stores: expv = memory dword afterwards
  localparam vec_t VEC [NV] = '{
    '{3'd0, 64'h100, 16'h0001, 64'h00000000112233FF},
    '{3'd0, 64'h110, 16'hFFF6, 64'h000000006677EEFF},
    '{3'd0, 64'h100, 16'h0000, 64'h0000000000112233},
    '{3'd1, 64'h100, 16'h0002, 64'hFFFFFFFFCC001122},
    '{3'd1, 64'h103, 16'h0000, 64'h0000000000112233},
    '{3'd1, 64'h108, 16'hFFFC, 64'hFFFFFFFFCCDDEE44},
    '{3'd2, 64'h100, 16'h0003, 64'h3344556677DDEEFF},
    '{3'd2, 64'h100, 16'h0000, 64'h0011223344556677},
    '{3'd3, 64'h100, 16'h0005, 64'h8899001122334455},
    '{3'd3, 64'h107, 16'h0000, 64'h0011223344556677},
    '{3'd4, 64'h100, 16'h0001, 64'h00CCDDEE44556677},
    '{3'd4, 64'h100, 16'h0000, 64'hCCDDEEFF44556677},
    '{3'd5, 64'h100, 16'h0006, 64'h00112233DDEEFF77},
    '{3'd6, 64'h100, 16'h0002, 64'h00118899AABBCCDD},
    '{3'd7, 64'h100, 16'h0004, 64'hBBCCDDEEFF556677},
    '{3'd7, 64'h200, 16'hFF07, 64'h8899AABBCCDDEEFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] base_i = '0;
  logic [15:0] imm_i = '0;
  logic [63:0] rt_i = '0;
  logic        addr64_i = 1'b1;
  logic        mem_req_o, mem_we_o, mem_size_o;
  logic [63:0] mem_addr_o, mem_wdata_o;
  logic        mem_gnt_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        rf_we_o, done_o, exc_o;
  logic [63:0] rf_wdata_o;
  logic [1:0]  exc_code_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench memory model and monitors
  logic [63:0] mem [8];
  logic        cap_we, cap_size;
  logic [63:0] cap_addr, cap_wdata, first_addr;
  int          n_rd, n_wr, n_rf, n_done, n_exc;
  logic [63:0] last_rf;
  logic [1:0]  last_code;

  always #4 clk = ~clk;

  partial_access_unit i_partial_access_unit (
    .clk (clk), .rst (rst), .start_i (start_i), .op_i (op_i),
    .base_i (base_i), .imm_i (imm_i), .rt_i (rt_i), .addr64_i (addr64_i),
    .mem_req_o (mem_req_o), .mem_we_o (mem_we_o), .mem_size_o (mem_size_o),
    .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o),
    .mem_gnt_i (mem_gnt_i), .mem_rvalid_i (mem_rvalid_i), .mem_rdata_i (mem_rdata_i),
    .rf_we_o (rf_we_o), .rf_wdata_o (rf_wdata_o), .done_o (done_o),
    .exc_o (exc_o), .exc_code_o (exc_code_o)
  );

  always @(negedge clk) begin
    if (rf_we_o) begin n_rf++; last_rf = rf_wdata_o; end
    if (done_o) n_done++;
    if (exc_o) begin n_exc++; last_code = exc_code_o; end
    mem_rvalid_i = 1'b0;
    if (mem_gnt_i) begin
      mem_gnt_i = 1'b0;
      if (!cap_we) begin
        mem_rvalid_i = 1'b1;
        if (cap_size) mem_rdata_i = mem[cap_addr[5:3]];
        else mem_rdata_i = {32'h0, cap_addr[2] ? mem[cap_addr[5:3]][31:0]
                                               : mem[cap_addr[5:3]][63:32]};
      end
    end else if (mem_req_o) begin
      mem_gnt_i = 1'b1;
      cap_we = mem_we_o; cap_size = mem_size_o;
      cap_addr = mem_addr_o; cap_wdata = mem_wdata_o;
      if (cap_we) begin
        n_wr++;
        if (cap_size) mem[cap_addr[5:3]] = cap_wdata;
        else if (cap_addr[2]) mem[cap_addr[5:3]][31:0] = cap_wdata[31:0];
        else mem[cap_addr[5:3]][63:32] = cap_wdata[31:0];
      end else begin
        if (n_rd == 0) first_addr = mem_addr_o;
        n_rd++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [63:0] base, input logic [15:0] imm,
                        input logic wide, input bit poke);
    @(negedge clk);
    for (int i = 0; i < 8; i++) mem[i] = PATTERN;
    n_rd = 0; n_wr = 0; n_rf = 0; n_done = 0; n_exc = 0; first_addr = '0;
    op_i = op; base_i = base; imm_i = imm; rt_i = RTVAL; addr64_i = wide; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      op_i = 3'd6; base_i = 64'h100; imm_i = 16'h0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int c = 0; c < 50 && (n_done + n_exc) == 0; c++) @(negedge clk);
    if ((n_done + n_exc) == 0) chk(1'b0, "timeout", 64'(n_done), 64'd1);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(!mem_req_o && !rf_we_o && !done_o && !exc_o && !mem_we_o, "R10 outputs low in reset",
        64'({mem_req_o, rf_we_o, done_o, exc_o, mem_we_o}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req_o && !done_o && !exc_o, "R10 idle after reset",
        64'({mem_req_o, done_o, exc_o}), 64'd0);

    // table: R2 R3 R4 (loads), R5 R6 (stores), R1 address, R7 transfer counts
    for (int v = 0; v < NV; v++) begin
      logic [63:0] ea, al;
      run_op(VEC[v].op, VEC[v].base, VEC[v].imm, 1'b1, 1'b0);
      ea = VEC[v].base + {{48{VEC[v].imm[15]}}, VEC[v].imm};
      al = VEC[v].op[1] ? {ea[63:3], 3'b000} : {ea[63:2], 2'b00};
      chk(first_addr == al, "R1 aligned address", first_addr, al);
      if (VEC[v].op[2]) begin
        chk(mem[0] == VEC[v].expv, "R5/R6 store merge", mem[0], VEC[v].expv);
        chk(n_rd == 1 && n_wr == 1 && n_rf == 0 && n_done == 1, "R7 store one read one write",
            64'({8'(n_rd), 8'(n_wr), 8'(n_rf), 8'(n_done)}), 64'h01010001);
      end else begin
        chk(last_rf == VEC[v].expv, "R2/R3/R4 load merge", last_rf, VEC[v].expv);
        chk(n_rd == 1 && n_wr == 0 && n_rf == 1 && n_done == 1, "R7 load one read",
            64'({8'(n_rd), 8'(n_wr), 8'(n_rf), 8'(n_done)}), 64'h01000101);
      end
    end

    // R8 R9: 32-bit mode, 0x7FFFFFFF + 1 crosses sign boundary, load fault
    run_op(3'd0, 64'h7FFFFFFF, 16'h0001, 1'b0, 1'b0);
    chk(n_exc == 1 && last_code == 2'd1, "R9 load fault code", 64'(last_code), 64'd1);
    chk(n_rd == 0 && n_rf == 0 && n_done == 0, "R9 load fault no side effect",
        64'(n_rd + n_rf + n_done), 64'd0);

    // R8 R9: store fault, memory untouched
    run_op(3'd7, 64'h0000000100000100, 16'h0000, 1'b0, 1'b0);
    chk(n_exc == 1 && last_code == 2'd2, "R9 store fault code", 64'(last_code), 64'd2);
    chk(n_rd == 0 && n_wr == 0 && mem[0] == PATTERN, "R9 store fault memory kept", mem[0], PATTERN);

    // R8: same address in 64-bit mode is legal
    run_op(3'd2, 64'h0000000100000100, 16'h0000, 1'b1, 1'b0);
    chk(n_exc == 0 && last_rf == PATTERN, "R8 wide mode no fault", last_rf, PATTERN);

    // R8: sign-extended high address is legal in 32-bit mode
    run_op(3'd3, 64'hFFFFFFFF80000107, 16'h0000, 1'b0, 1'b0);
    chk(n_exc == 0 && last_rf == PATTERN, "R8 sign-extended address legal", last_rf, PATTERN);

    // R11: start pulsed mid-operation is ignored
    run_op(3'd0, 64'h100, 16'h0001, 1'b1, 1'b1);
    chk(n_rd == 1 && n_wr == 0 && n_done == 1, "R11 start while busy ignored",
        64'({8'(n_rd), 8'(n_wr), 8'(n_done)}), 64'h010001);
    chk(last_rf == 64'h00000000112233FF, "R11 first op result kept", last_rf, 64'h00000000112233FF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule